// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital half of a successive-approximation converter. Software sets it up through one mode register. That register holds the analog channel number, the conversion clock divider choice, a start/stop bit, and a read-only end-of-conversion flag. Once started, the sequencer divides the system clock down to a conversion clock and spends a fixed setup period. It then resolves the result one bit per slot, from the most significant bit down. In each slot it drives a trial code to an external DAC and reads back a single comparator decision.

A full conversion is 66 conversion-clock ticks:
- 10 setup ticks.
- 12 decision slots of 4 ticks each.
- 2 closing slots of 4 ticks each.

On the final tick the 12-bit result is copied into a high and a low result register, and the flag is raised in the same clock. There is no interrupt, so software polls the flag.

The state machine has four states:
- `ST_IDLE`: waiting for a start write.
- `ST_SETUP`: counting the setup ticks.
- `ST_DECIDE`: trial bit slots.
- `ST_CLOSE`: closing slots.

Transitions:
- A start write moves any state to `ST_SETUP`.
- A write of start/stop = 0 moves any state to `ST_IDLE`.
- The last setup tick moves `ST_SETUP` to `ST_DECIDE`.
- The fourth tick of the bit-0 slot moves `ST_DECIDE` to `ST_CLOSE`.
- The last closing tick moves `ST_CLOSE` to `ST_IDLE` and completes the conversion.

Top module: `adc_sar_seq`

## Requirements
- R1: After reset, the mode read-back, both result registers and the DAC trial code are all zero.
- R2: Mode bit 6 is start/stop. A write with bit 6 = 1 starts a conversion, or restarts one already in progress. In the next cycle the read-back shows bit 6 = 1 and the EOC flag (bit 7) = 0.
- R3: When a conversion completes, EOC is set and bit 6 is cleared in the same clock, and the block goes idle. EOC and bit 6 are never both 1.
- R4: A conversion takes 66 conversion-clock ticks. EOC reads 1 exactly 66*D system clocks after the clock edge that accepted the start write, and reads 0 one clock earlier.
- R5: Mode bits [5:4] select the divider D: 00 gives 2, 01 gives 4, 10 gives 8 and 11 gives 16.
- R6: The bits are resolved from MSB to LSB. The first trial code, presented right after setup, is 0x800. Each trial bit is kept when the comparator input is 1 (analog level at or above the trial code) and cleared otherwise. The final result is the analog level as seen through an ideal comparator.
- R7: The low result register holds result bits [7:0]. The high result register holds bits [11:8] in its low nibble, with the upper bits zero. The result registers keep their previous value until completion, and change only in the clock in which EOC rises.
- R8: A write with bit 6 = 0 during a conversion aborts it. EOC stays 0, the result registers stay unchanged, and the DAC trial code returns to zero.
- R9: Mode bits [3:0] select the analog channel, and the channel is driven on `adc_chan`. The channel and divider fields are written by every mode write.
- R10: The DAC trial code is zero whenever the block is not in a bit-decision slot, which includes the setup period and idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Mode register write strobe |
| wr_data | input | 7 | Writable mode fields: [6] start/stop, [5:4] divider, [3:0] channel |
| cmp_in | input | 1 | Comparator decision, 1 when the analog level is at or above the trial code |
| mode_rd | output | 8 | Mode read-back: [7] EOC, [6] start/stop, [5:4] divider, [3:0] channel |
| res_hi | output | 8 | High result register (result bits [11:8] in [3:0]) |
| res_lo | output | 8 | Low result register (result bits [7:0]) |
| adc_chan | output | 4 | Selected analog channel |
| dac_code | output | 12 | Trial code to the external DAC |

## Verification
The assertions assume that the comparator answers from the current trial code within the same cycle and is otherwise steady. They also assume that the divider field changes only together with a start write, so that the length check can trust the divider it reads back. The bench models the comparator as a pure compare of a fixed per-channel level against `dac_code`. It writes the mode register only to start, restart or abort a conversion, so the divider never moves under a running conversion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_DECIDE,
        ST_CLOSE
    } seq_state_e;

endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
    parameter int SEL_W = 2,
    localparam int CNT_W = 2 ** SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    // divisor is 2 << sel, so the count wraps at (2 << sel) - 1
    assign limit = CNT_W'((32'd2 << sel) - 32'd1);
    assign tick  = run && (cnt == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int RES_W          = 12,
    parameter int SETUP_TICKS    = 10,
    parameter int EDGES_PER_SLOT = 4,
    parameter int CLOSE_SLOTS    = 2,
    localparam int IDX_W         = $clog2(RES_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic             abort_req,
    input  logic             tick,
    output logic [IDX_W-1:0] bit_idx,
    output logic             decide,
    output logic             done,
    output logic             trial_en,
    output logic             run,
    output logic             clr_div
);

    localparam int CLOSE_TICKS = CLOSE_SLOTS * EDGES_PER_SLOT;
    localparam int MAX_A       = (SETUP_TICKS > EDGES_PER_SLOT) ? SETUP_TICKS : EDGES_PER_SLOT;
    localparam int MAX_CNT     = (MAX_A > CLOSE_TICKS) ? MAX_A : CLOSE_TICKS;
    localparam int CNT_W       = $clog2(MAX_CNT + 1);

    localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_TICKS - 1);
    localparam logic [CNT_W-1:0] EDGE_LAST  = CNT_W'(EDGES_PER_SLOT - 1);
    localparam logic [CNT_W-1:0] CLOSE_LAST = CNT_W'(CLOSE_TICKS - 1);
    localparam logic [IDX_W-1:0] IDX_TOP    = IDX_W'(RES_W - 1);

    seq_state_e       state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic [IDX_W-1:0] idx_nx;
    logic             wr_hit;

    assign wr_hit = start_req || abort_req;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
        end else begin
            state   <= state_nx;
            cnt     <= cnt_nx;
            bit_idx <= idx_nx;
        end
    end

    // next state and counters; software writes take priority over ticks
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        idx_nx   = bit_idx;
        if (start_req) begin
            state_nx = ST_SETUP;
            cnt_nx   = '0;
            idx_nx   = IDX_TOP;
        end else if (abort_req) begin
            state_nx = ST_IDLE;
            cnt_nx   = '0;
        end else if (tick) begin
            unique case (state)
                ST_IDLE: begin
                    cnt_nx = '0;
                end
                ST_SETUP: begin
                    if (cnt == SETUP_LAST) begin
                        state_nx = ST_DECIDE;
                        cnt_nx   = '0;
                    end else begin
                        cnt_nx = cnt + 1'b1;
                    end
                end
                ST_DECIDE: begin
                    if (cnt == EDGE_LAST) begin
                        cnt_nx = '0;
                        if (bit_idx == '0) begin
                            state_nx = ST_CLOSE;
                        end else begin
                            idx_nx = bit_idx - 1'b1;
                        end
                    end else begin
                        cnt_nx = cnt + 1'b1;
                    end
                end
                ST_CLOSE: begin
                    if (cnt == CLOSE_LAST) begin
                        state_nx = ST_IDLE;
                        cnt_nx   = '0;
                    end else begin
                        cnt_nx = cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        run      = (state != ST_IDLE);
        trial_en = (state == ST_DECIDE);
        clr_div  = start_req;
        decide   = trial_en && tick && (cnt == EDGE_LAST) && !wr_hit;
        done     = (state == ST_CLOSE) && tick && (cnt == CLOSE_LAST) && !wr_hit;
    end

endmodule

// File: rtl/adc_sar_reg.sv
module adc_sar_reg #(
    parameter int RES_W   = 12,
    localparam int IDX_W  = $clog2(RES_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             decide,
    input  logic             trial_en,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             cmp_in,
    output logic [RES_W-1:0] code,
    output logic [RES_W-1:0] dac_code
);

    logic [RES_W-1:0] mask;

    assign mask     = RES_W'(1) << bit_idx;
    // bits below the trial position are still zero, so OR-ing the mask sets the trial
    assign dac_code = trial_en ? (code | mask) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code <= '0;
        end else if (clear) begin
            code <= '0;
        end else if (decide) begin
            code <= (code & ~mask) | (cmp_in ? mask : '0);
        end
    end

endmodule

// File: rtl/adc_sar_seq.sv
module adc_sar_seq #(
    parameter int RES_W          = 12,
    parameter int CHAN_W         = 4,
    parameter int SEL_W          = 2,
    parameter int SETUP_TICKS    = 10,
    parameter int EDGES_PER_SLOT = 4,
    parameter int CLOSE_SLOTS    = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [CHAN_W+SEL_W:0]   wr_data,
    input  logic                    cmp_in,
    output logic [CHAN_W+SEL_W+1:0] mode_rd,
    output logic [7:0]              res_hi,
    output logic [7:0]              res_lo,
    output logic [CHAN_W-1:0]       adc_chan,
    output logic [RES_W-1:0]        dac_code
);

    localparam int SEL_LSB   = CHAN_W;
    localparam int START_BIT = CHAN_W + SEL_W;
    localparam int IDX_W     = $clog2(RES_W);

    logic [CHAN_W-1:0] chan_q;
    logic [SEL_W-1:0]  sel_q;
    logic              start_q;
    logic              eoc_q;
    logic [RES_W-1:0]  result_q;

    logic              start_req;
    logic              abort_req;
    logic              tick;
    logic [IDX_W-1:0]  bit_idx;
    logic              decide;
    logic              done;
    logic              trial_en;
    logic              run;
    logic              clr_div;
    logic [RES_W-1:0]  code;

    assign start_req = wr_en && wr_data[START_BIT];
    assign abort_req = wr_en && !wr_data[START_BIT];

    adc_clk_div #(
        .SEL_W (SEL_W)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_div),
        .run   (run),
        .sel   (sel_q),
        .tick  (tick)
    );

    adc_seq_fsm #(
        .RES_W          (RES_W),
        .SETUP_TICKS    (SETUP_TICKS),
        .EDGES_PER_SLOT (EDGES_PER_SLOT),
        .CLOSE_SLOTS    (CLOSE_SLOTS)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .abort_req (abort_req),
        .tick      (tick),
        .bit_idx   (bit_idx),
        .decide    (decide),
        .done      (done),
        .trial_en  (trial_en),
        .run       (run),
        .clr_div   (clr_div)
    );

    adc_sar_reg #(
        .RES_W (RES_W)
    ) u_sar (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (start_req),
        .decide   (decide),
        .trial_en (trial_en),
        .bit_idx  (bit_idx),
        .cmp_in   (cmp_in),
        .code     (code),
        .dac_code (dac_code)
    );

    // mode register with hardware-updated handshake bits, and result capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_q   <= '0;
            sel_q    <= '0;
            start_q  <= 1'b0;
            eoc_q    <= 1'b0;
            result_q <= '0;
        end else if (wr_en) begin
            chan_q  <= wr_data[CHAN_W-1:0];
            sel_q   <= wr_data[SEL_LSB +: SEL_W];
            start_q <= wr_data[START_BIT];
            if (wr_data[START_BIT]) begin
                eoc_q <= 1'b0;
            end
        end else if (done) begin
            start_q  <= 1'b0;
            eoc_q    <= 1'b1;
            result_q <= code;
        end
    end

    assign mode_rd  = {eoc_q, start_q, sel_q, chan_q};
    assign adc_chan = chan_q;
    assign res_lo   = result_q[7:0];
    assign res_hi   = 8'(result_q >> 8);

endmodule

// File: rtl/adc_sar_seq_chk.sv
module adc_sar_seq_chk #(
    parameter int TOTAL_TICKS = 66
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [6:0]  wr_data,
    input logic [7:0]  mode_rd,
    input logic [7:0]  res_hi,
    input logic [7:0]  res_lo,
    input logic [11:0] dac_code
);

    logic        eoc;
    logic        busy;
    logic [15:0] run_len;

    assign eoc  = mode_rd[7];
    assign busy = mode_rd[6];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (wr_en && wr_data[6]) begin
            run_len <= '0;
        end else if (busy) begin
            run_len <= run_len + 1'b1;
        end
    end

    // R2
    a_r2_start_clears_eoc: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[6]) |=> (!eoc && busy));

    // R3
    a_r3_done_clears_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eoc) |-> !busy);

    // R3
    a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(eoc && busy));

    // R4, R5
    a_r4_conversion_length: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eoc) |-> (32'(run_len) == TOTAL_TICKS * (32'd2 << mode_rd[5:4])));

    // R7
    a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(eoc) |-> $stable({res_hi, res_lo}));

    // R8
    a_r8_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[6] && busy) |=> (!eoc && !busy && dac_code == 12'd0));

    // R10
    a_r10_dac_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (dac_code == 12'd0));

endmodule

bind adc_sar_seq adc_sar_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .mode_rd  (mode_rd),
    .res_hi   (res_hi),
    .res_lo   (res_lo),
    .dac_code (dac_code)
);

// File: tb/adc_sar_seq_test.sv
module adc_sar_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [6:0]  wr_data = '0;
    logic        cmp_in;
    logic [7:0]  mode_rd;
    logic [7:0]  res_hi;
    logic [7:0]  res_lo;
    logic [3:0]  adc_chan;
    logic [11:0] dac_code;

    logic [11:0] level [0:15];
    logic [11:0] exp_q [$];
    logic        eoc_seen = 1'b0;
    int          n_chk = 0;
    int          n_fail = 0;

    always #10 clk = ~clk;

    assign cmp_in = (level[adc_chan] >= dac_code);

    adc_sar_seq uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .cmp_in   (cmp_in),
        .mode_rd  (mode_rd),
        .res_hi   (res_hi),
        .res_lo   (res_lo),
        .adc_chan (adc_chan),
        .dac_code (dac_code)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic write_mode(input logic [6:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // driver: pushes the expected result, starts, and checks timing
    task automatic run_conv(input logic [3:0] ch, input logic [1:0] sel);
        int div;
        logic [15:0] prev;
        div  = 2 << sel;
        prev = {res_hi, res_lo};
        exp_q.push_back(level[ch]);
        write_mode({1'b1, sel, ch});
        chk("R2 start/eoc", 32'(mode_rd[7:6]), 32'h1);
        chk("R9 channel", 32'(adc_chan), 32'(ch));
        chk("R5 divider field", 32'(mode_rd[5:4]), 32'(sel));
        for (int i = 1; i < 66 * div; i++) begin
            @(negedge clk);
            if (i == 1) begin
                chk("R10 dac in setup", 32'(dac_code), 32'h0);
                chk("R7 result held", 32'({res_hi, res_lo}), 32'(prev));
            end
            if (i == 10 * div) begin
                chk("R6 first trial", 32'(dac_code), 32'h800);
            end
        end
        chk("R4 eoc one clock early", 32'(mode_rd[7]), 32'h0);
        @(negedge clk);
        chk("R4 eoc at 66 ticks", 32'(mode_rd[7]), 32'h1);
        chk("R3 start cleared", 32'(mode_rd[6]), 32'h0);
        chk("R10 dac idle", 32'(dac_code), 32'h0);
    endtask

    // monitor: compares each completed result with the scoreboard
    always @(negedge clk) begin
        if (rst_n && mode_rd[7] && !eoc_seen) begin
            if (exp_q.size() == 0) begin
                chk("R3 unexpected completion", 32'h1, 32'h0);
            end else begin
                logic [11:0] e;
                e = exp_q.pop_front();
                chk("R6 result value", 32'({res_hi[3:0], res_lo}), 32'(e));
                chk("R7 high upper bits", 32'(res_hi[7:4]), 32'h0);
            end
        end
        eoc_seen = mode_rd[7];
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] prev;
        for (int k = 0; k < 16; k++) level[k] = 12'(k * 257);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 mode reset", 32'(mode_rd), 32'h0);
        chk("R1 result reset", 32'({res_hi, res_lo}), 32'h0);
        chk("R1 dac reset", 32'(dac_code), 32'h0);

        write_mode(7'h25);
        chk("R9 fields written", 32'(mode_rd), 32'h25);
        chk("R9 channel out", 32'(adc_chan), 32'h5);

        level[3]  = 12'hA5A; run_conv(4'd3, 2'd0);
        level[0]  = 12'h000; run_conv(4'd0, 2'd2);
        level[15] = 12'hFFF; run_conv(4'd15, 2'd1);
        level[7]  = 12'h800; run_conv(4'd7, 2'd3);
        level[9]  = 12'h7FF; run_conv(4'd9, 2'd0);
        level[2]  = 12'h001; run_conv(4'd2, 2'd0);

        // R8 abort mid conversion
        level[1] = 12'h123;
        prev = {res_hi, res_lo};
        write_mode({1'b1, 2'd0, 4'd1});
        repeat (100) @(negedge clk);
        chk("R8 trial active before abort", 32'(dac_code != 12'd0), 32'h1);
        write_mode({1'b0, 2'd0, 4'd1});
        chk("R8 flags after abort", 32'(mode_rd[7:6]), 32'h0);
        chk("R8 dac after abort", 32'(dac_code), 32'h0);
        chk("R8 result kept", 32'({res_hi, res_lo}), 32'(prev));
        repeat (300) @(negedge clk);
        chk("R8 no late completion", 32'(mode_rd[7]), 32'h0);
        chk("R8 result still kept", 32'({res_hi, res_lo}), 32'(prev));

        // R2 restart during a conversion
        level[4] = 12'h3C3;
        level[6] = 12'h5A5;
        write_mode({1'b1, 2'd0, 4'd4});
        repeat (40) @(negedge clk);
        run_conv(4'd6, 2'd0);

        repeat (5) @(negedge clk);
        chk("R3 scoreboard drained", 32'(exp_q.size()), 32'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule